// File: doc/BRIEF.md
# Colour Palette Look-up Table

The block holds a 256-colour look-up table. Software loads and reads the table through a simple word-wide register port. A pixel pipeline reads the same table through a separate look-up port. Each 32-bit storage word holds two 16-bit colour entries. Each entry has three 5-bit channels and one intensity flag.

On the look-up side, an 8-bit pixel index selects a word and one half of that word. Each 5-bit channel is widened to 8 bits by appending three zero bits, and the result is a 24-bit colour returned one clock later. The intensity flag plays no part in the output colour.

A register write and a look-up in the same cycle see one coherent table: a look-up or read that hits the word being written returns the new data. After reset every word is zero, so every look-up returns black.

Top module: `pal_lut`

## Requirements
- R1: After reset every storage word is zero. Register reads return 0 and look-ups return 24'h000000.
- R2: A write with `bus_addr_i` = 0x200 + 4·n (n in 0..127) stores `bus_wdata_i` in word n. A later read of the same address returns that exact 32-bit value on `bus_rdata_o`, one cycle after the read strobe, with `bus_rvld_o` high.
- R3: Look-up index 2n uses bits [15:0] of word n. Index 2n+1 uses bits [31:16] of word n.
- R4: Within a selected 16-bit entry, bits [4:0] drive `rgb_o[7:3]`, bits [9:5] drive `rgb_o[15:11]` and bits [14:10] drive `rgb_o[23:19]`. Output bits [2:0], [10:8] and [18:16] are always 0.
- R5: Bit 15 of an entry (the intensity flag) has no effect on `rgb_o`.
- R6: `rgb_vld_o` equals `pix_vld_i` delayed by one cycle. `rgb_o` holds its value in any cycle after one in which `pix_vld_i` was low.
- R7: When a write and a look-up or read hit the same word in the same cycle, the result carries the newly written data.
- R8: An address outside 0x200..0x3FC, or one with bits [1:0] not zero, is not a palette hit. A write to it changes no word, and a read of it returns 0.
- R9: `bus_rvld_o` equals `bus_rd_i` delayed by one cycle. `bus_rdata_o` holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte address inside the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_rvld_o | output | 1 | Read data valid |
| pix_vld_i | input | 1 | Look-up request |
| pix_idx_i | input | 8 | Pixel index |
| rgb_o | output | 24 | Expanded colour |
| rgb_vld_o | output | 1 | Colour valid |

## Verification
The bench targets the following corner cases, each with the symptom a faulty design would show:
- **Same-cycle write and look-up of the same word.** A design without bypass returns the stale colour.
- **Odd versus even indices.** A swapped half-word select shows the neighbouring entry's colour.
- **Entries with only the intensity flag set.** A design that leaks the flag into a channel produces non-black output.
- **Addresses just outside the window and unaligned addresses.** A loose decoder corrupts word 0 or word 127, or returns non-zero read data.
- **Random writes, reads and look-ups.** These run against a table model and catch swapped channels or a wrong shift amount.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned CH_IN  = 5;
  localparam int unsigned CH_OUT = 8;
  localparam int unsigned N_CH   = 3;
  localparam int unsigned RGB_W  = N_CH * CH_OUT;
endpackage

// File: rtl/pal_store.sv
module pal_store #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // write-through bypass keeps both views coherent in the write cycle
  assign rdata_a_o = (we_i && waddr_i == raddr_a_i) ? wdata_i : mem_q[raddr_a_i];
  assign rdata_b_o = (we_i && waddr_i == raddr_b_i) ? wdata_i : mem_q[raddr_b_i];

  p_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

  p_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == raddr_b_i) |-> rdata_b_o == wdata_i);
endmodule

// File: rtl/pal_expand.sv
module pal_expand
  import pal_pkg::*;
(
  input  logic [2*HALF_W-1:0] word_i,
  input  logic                hi_i,
  output logic [RGB_W-1:0]    rgb_o
);
  logic [HALF_W-1:0] entry;

  assign entry = hi_i ? word_i[2*HALF_W-1:HALF_W] : word_i[HALF_W-1:0];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign rgb_o[c*CH_OUT +: CH_OUT] = {entry[c*CH_IN +: CH_IN], {(CH_OUT-CH_IN){1'b0}}};
  end
endmodule

// File: rtl/pal_lut.sv
module pal_lut
  import pal_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BASE   = 'h200,
  parameter int unsigned WORDS  = 128,
  localparam int unsigned DW    = 2 * HALF_W,
  localparam int unsigned WAW   = $clog2(WORDS),
  localparam int unsigned IDX_W = WAW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              bus_rvld_o,
  input  logic              pix_vld_i,
  input  logic [IDX_W-1:0]  pix_idx_i,
  output logic [RGB_W-1:0]  rgb_o,
  output logic              rgb_vld_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(WORDS * 4);

  logic [ADDR_W-1:0] addr_off;
  logic              pal_hit;
  logic [WAW-1:0]    bus_word;
  logic [DW-1:0]     bus_word_data;
  logic [DW-1:0]     pix_word_data;
  logic [RGB_W-1:0]  rgb_d;

  assign addr_off = bus_addr_i - BASE_A;
  assign pal_hit  = (bus_addr_i >= BASE_A) && (addr_off < SPAN_A) && (addr_off[1:0] == 2'b00);
  assign bus_word = addr_off[WAW+1:2];

  pal_store #(.WORDS(WORDS), .DW(DW)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_wr_i && pal_hit),
    .waddr_i   (bus_word),
    .wdata_i   (bus_wdata_i),
    .raddr_a_i (bus_word),
    .rdata_a_o (bus_word_data),
    .raddr_b_i (pix_idx_i[IDX_W-1:1]),
    .rdata_b_o (pix_word_data)
  );

  pal_expand i_expand (
    .word_i (pix_word_data),
    .hi_i   (pix_idx_i[0]),
    .rgb_o  (rgb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o       <= '0;
      rgb_vld_o   <= 1'b0;
      bus_rdata_o <= '0;
      bus_rvld_o  <= 1'b0;
    end else begin
      rgb_vld_o  <= pix_vld_i;
      bus_rvld_o <= bus_rd_i;
      if (pix_vld_i) rgb_o <= rgb_d;
      if (bus_rd_i)  bus_rdata_o <= pal_hit ? bus_word_data : '0;
    end
  end

  p_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rgb_vld_o == $past(pix_vld_i));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_i |=> $stable(rgb_o));

  p_low_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rgb_vld_o |-> (rgb_o[2:0] == 3'b0 && rgb_o[10:8] == 3'b0 && rgb_o[18:16] == 3'b0));

  p_oob_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !pal_hit) |=> bus_rdata_o == '0);

  p_rd_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvld_o == $past(bus_rd_i));
endmodule

// File: tb/test_pal_lut.sv
module test_pal_lut;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, pix_vld = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  pix_idx = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvld, rgb_vld;
  logic [23:0] rgb;

  int n_chk = 0, n_bad = 0;
  logic [31:0] model [128];
  logic [23:0] last_rgb = '0;
  logic [31:0] last_rd = '0;

  always #2 clk = ~clk;

  pal_lut i_pal_lut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvld_o(bus_rvld), .pix_vld_i(pix_vld), .pix_idx_i(pix_idx),
    .rgb_o(rgb), .rgb_vld_o(rgb_vld)
  );

  function automatic logic [23:0] exp_rgb(logic [31:0] w, logic hi);
    logic [15:0] e = hi ? w[31:16] : w[15:0];
    return {e[14:10], 3'b0, e[9:5], 3'b0, e[4:0], 3'b0};
  endfunction

  function automatic logic hit(logic [11:0] a);
    return a >= 12'h200 && a < 12'h400 && a[1:0] == 2'b00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [11:0] a,
                     input logic [31:0] wd, input logic pv, input logic [7:0] idx,
                     input string req);
    logic [31:0] erd;
    logic [23:0] ergb;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    pix_vld = pv; pix_idx = idx;
    if (wr && hit(a)) model[a[8:2]] = wd;   // R7: bypass sees the new word
    erd  = rd ? (hit(a) ? model[a[8:2]] : 32'h0) : last_rd;
    ergb = pv ? exp_rgb(model[idx[7:1]], idx[0]) : last_rgb;
    @(posedge clk); #1;
    check({req, "/R6 vld"}, {31'b0, rgb_vld}, {31'b0, pv});
    check({req, " rgb"}, {8'b0, rgb}, {8'b0, ergb});
    check({req, "/R9 rvld"}, {31'b0, bus_rvld}, {31'b0, rd});
    check({req, " rdata"}, bus_rdata, erd);
    last_rgb = ergb; last_rd = erd;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; pix_vld = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b));
    for (int i = 0; i < 128; i++) model[i] = '0;
    #9 rst_n = 1'b1;
    // R1: reset state
    #1 check("R1 rgb", {8'b0, rgb}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    cyc(0, 1, 12'h200, 0, 1, 8'd0,   "R1");
    cyc(0, 1, 12'h3FC, 0, 1, 8'd255, "R1");
    // R2/R3/R4 directed
    cyc(1, 0, 12'h204, 32'h7C1F_03E0, 0, 0, "R2");
    cyc(0, 1, 12'h204, 0, 1, 8'd2, "R3 low half R4");
    cyc(0, 1, 12'h204, 0, 1, 8'd3, "R3 high half R4");
    // R5: intensity only, and full channels with intensity
    cyc(1, 0, 12'h208, 32'h8000_FFFF, 0, 0, "R5");
    cyc(0, 0, 12'h208, 0, 1, 8'd5, "R5 flag only");
    cyc(0, 1, 12'h208, 0, 1, 8'd4, "R5 full");
    // R7: same-cycle write and lookup/read
    cyc(1, 1, 12'h20C, 32'h1234_5678, 1, 8'd6, "R7 low");
    cyc(1, 1, 12'h20C, 32'h4321_8765, 1, 8'd7, "R7 high");
    // R8: out-of-window and unaligned writes ignored
    cyc(1, 1, 12'h1FC, 32'hFFFF_FFFF, 1, 8'd0,   "R8 below");
    cyc(1, 1, 12'h400, 32'hFFFF_FFFF, 1, 8'd255, "R8 above");
    cyc(1, 1, 12'h202, 32'hFFFF_FFFF, 1, 8'd1,   "R8 unaligned");
    cyc(0, 1, 12'h200, 0, 1, 8'd0,   "R8 word0");
    cyc(0, 1, 12'h3FC, 0, 1, 8'd254, "R8 word127");
    // R6/R9: hold when idle
    cyc(0, 0, 12'h204, 0, 0, 8'd3, "R6 R9 hold");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] a;
      a = ($urandom % 8 == 0) ? 12'($urandom) : 12'h200 + 12'(($urandom % 128) * 4);
      cyc(1'($urandom), 1'($urandom), a, $urandom, 1'($urandom % 4 != 0),
          8'($urandom), "R2 R3 R4 R5 R7 R8 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule